// File: doc/BRIEF.md
# Leveled Core-Local Interrupt Controller

This block collects up to `NUM_SRC` interrupt lines next to a processor core and decides which one the core should take. A small 32-bit register bus with byte strobes programs it. Each source has four bytes of state: pending, enable, trigger/vector attributes and an 8-bit control byte. The control byte is split at run time into an upper level field and a lower priority field. A global width setting moves the split point.

A global threshold masks every source whose level does not exceed it. Among the sources that are pending, enabled and above the threshold, the controller presents one winner to the core, with its ID, its level and a flag that says whether the core should vector directly to it. The core pulses an acknowledge strobe when it takes the interrupt. For edge-triggered sources this clears the pending bit of the presented source. Level-triggered sources keep tracking their line.

Top module: `core_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the following are zero: the level width, the threshold, and every pending, enable, trigger, vector and implemented control bit. `irq_valid` is 0.
- R2: Register map, with word address = `reg_addr[15:2]`. Global configuration is byte 0 of 0x0000 and reads `{1'b0, 2'b00, width[3:0], 1'b1}`. The threshold is byte 3 of 0x0008. For source i, word 0x1000+4i holds pending (byte 0, bit 0), enable (byte 1, bit 0), attribute (byte 2) and control (byte 3). The attribute byte reads `{2'b11, 3'b000, trig[1:0], vec}`. The pending and enable bytes read zero in bits 7:1. The low `8-CTL_BITS` control bits read as 1. Any other address reads 0.
- R3: The read-only word at 0x0004 reads `{7'b0, CTL_BITS[3:0], VERSION[7:0], NUM_SRC[12:0]}`. The defaults are 4, 1 and 87.
- R4: A write changes only the bytes whose `reg_be` bit is set. Writes to read-only bits and unmapped bytes have no effect.
- R5: With trigger code 00 or 10 (level), the pending bit equals the source line sampled at the previous clock edge. Software writes to it have no effect, and so does an acknowledge.
- R6: With trigger code 01 (rising edge), a 0-to-1 transition of the line sets the pending bit at the next edge. The bit stays set after the line falls.
- R7: With trigger code 11 (falling edge), a 1-to-0 transition of the line sets the pending bit at the next edge. A rising transition does not set it.
- R8: For edge modes, a software write of bit 0 sets or clears the pending bit. An acknowledge while the source is presented clears it. A detected edge in the same cycle wins over either clear.
- R9: A source is eligible when it is pending, enabled and its level is strictly greater than the threshold. The level is the upper `width` bits of the control byte, read as an unsigned number. A width of 0 gives level 255, and a width above 8 is treated as 8.
- R10: Among eligible sources the highest level wins. A tie goes to the highest value of the remaining low control bits, and a further tie goes to the highest source ID.
- R11: `irq_valid`, `irq_id`, `irq_level` and `irq_vec` follow the registered state with no extra delay, so they change in the cycle after a line or register change. With no winner, `irq_level` and `irq_vec` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt lines, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte lane enables for writes |
| reg_addr | input | ADDR_W | Byte address (low two bits ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_ack | input | 1 | Core takes the presented interrupt |
| irq_valid | output | 1 | A source is being presented |
| irq_id | output | ID_W | ID of the presented source |
| irq_level | output | 8 | Level of the presented source |
| irq_vec | output | 1 | Presented source requests direct vectoring |

## Verification
Some properties are checked on every cycle. A level-mode pending bit must track the previous line sample. A detected rising or falling edge must set the pending bit. An unobstructed acknowledge must clear an edge source. The presented source must be eligible, and its level must exceed the threshold. Other behaviour only shows up in the bench scenarios. These are the ordering between level, priority and ID across many width settings, the saturation of the width at 0 and above 8, the byte-lane and read-only masking, and the exact cycle in which a new line changes the presented ID.

// File: rtl/irqc_pkg.sv
// Shared types and helpers for the leveled interrupt controller.
// Assumes: control bytes are 8 bits wide and the level width field is 4 bits.
package irqc_pkg;

    // Trigger codes held in the attribute byte bits 2:1.
    typedef enum logic [1:0] {
        TRG_LEVEL_A = 2'b00,
        TRG_RISE    = 2'b01,
        TRG_LEVEL_B = 2'b10,
        TRG_FALL    = 2'b11
    } trig_e;

    // Level of a source from its effective control byte and the level width.
    function automatic logic [7:0] level_of(input logic [7:0] ctl, input logic [3:0] width);
        logic [3:0] w;
        w = (width > 4'd8) ? 4'd8 : width;
        if (w == 4'd0) begin
            return 8'hFF;
        end
        return ctl >> (4'd8 - w);
    endfunction

endpackage

// File: rtl/irqc_globals.sv
// Global registers: the level width setting, the threshold and the
// read-only information word.
// Assumes: the top decodes word 0 and word 2 and passes the write strobes.
module irqc_globals #(
    parameter int NUM_SRC  = 87,
    parameter int CTL_BITS = 4,
    parameter int VERSION  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_cfg,
    input  logic        wr_thr,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [3:0]  width,
    output logic [7:0]  thr,
    output logic [31:0] cfg_word,
    output logic [31:0] thr_word,
    output logic [31:0] info_word
);

    logic unused_wr;

    // Level width register: bits 4:1 of byte 0 at word 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width <= 4'd0;
        end else if (wr_cfg && wr_be[0]) begin
            width <= wr_data[4:1];
        end
    end

    // Threshold register: byte 3 at word 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= 8'd0;
        end else if (wr_thr && wr_be[3]) begin
            thr <= wr_data[31:24];
        end
    end

    // Read views with fixed bits filled in.
    always_comb begin
        cfg_word  = {24'd0, 1'b0, 2'b00, width, 1'b1};
        thr_word  = {thr, 24'd0};
        info_word = {7'd0, 4'(CTL_BITS), 8'(VERSION), 13'(NUM_SRC)};
    end

    assign unused_wr = ^wr_data;

endmodule

// File: rtl/irqc_slot.sv
// One interrupt source: pending, enable, trigger, vector and control state,
// together with edge detection, level derivation and the eligibility test.
// Assumes: src_in is synchronous to clk, and ack_hit is high only while this
// source is the one presented to the core.
module irqc_slot
    import irqc_pkg::*;
#(
    parameter int CTL_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        src_in,
    input  logic        wr_sel,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    input  logic        ack_hit,
    input  logic [3:0]  width,
    input  logic [7:0]  thr,
    output logic        eligible,
    output logic [7:0]  key,
    output logic [7:0]  level,
    output logic        vec,
    output logic [31:0] rd_word
);

    localparam int LOW_BITS = 8 - CTL_BITS;

    logic                pend_q;
    logic                en_q;
    trig_e               trig_q;
    logic                vec_q;
    logic [CTL_BITS-1:0] ctl_q;
    logic                prev_q;
    logic [7:0]          eff_ctl;
    logic                edge_hit;
    logic                sw_pend;
    logic                unused_wr;

    // Pad the implemented control bits with ones below them.
    generate
        if (LOW_BITS == 0) begin : g_full_ctl
            assign eff_ctl = ctl_q;
        end else begin : g_part_ctl
            assign eff_ctl = {ctl_q, {LOW_BITS{1'b1}}};
        end
    endgenerate

    // Edge detection for the two edge trigger codes.
    always_comb begin
        case (trig_q)
            TRG_RISE: edge_hit = !prev_q && src_in;
            TRG_FALL: edge_hit = prev_q && !src_in;
            default:  edge_hit = 1'b0;
        endcase
        sw_pend = wr_sel && wr_be[0];
    end

    // Previous line sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_in;
    end

    // Pending bit: follow the line, or set on edge / write / clear on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!trig_q[0]) begin
            pend_q <= src_in;
        end else if (edge_hit) begin
            pend_q <= 1'b1;
        end else if (sw_pend) begin
            pend_q <= wr_data[0];
        end else if (ack_hit) begin
            pend_q <= 1'b0;
        end
    end

    // Enable, attribute and control bytes written by lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            trig_q <= TRG_LEVEL_A;
            vec_q  <= 1'b0;
            ctl_q  <= '0;
        end else if (wr_sel) begin
            if (wr_be[1]) en_q <= wr_data[8];
            if (wr_be[2]) begin
                trig_q <= trig_e'(wr_data[18:17]);
                vec_q  <= wr_data[16];
            end
            if (wr_be[3]) ctl_q <= wr_data[31 -: CTL_BITS];
        end
    end

    // Level, eligibility and read view.
    always_comb begin
        level    = level_of(eff_ctl, width);
        eligible = pend_q && en_q && (level > thr);
        key      = eff_ctl;
        vec      = vec_q;
        rd_word  = {eff_ctl, 2'b11, 3'b000, trig_q, vec_q, 7'd0, en_q, 7'd0, pend_q};
    end

    assign unused_wr = ^wr_data;

    // R5: a level-mode pending bit equals the line seen one edge earlier.
    p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(trig_q[0])) |-> (pend_q == $past(src_in)));

    // R6: a rising edge in rising mode sets pending at the next edge.
    p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q == TRG_RISE && !prev_q && src_in) |=> pend_q);

    // R7: a falling edge in falling mode sets pending at the next edge.
    p_fall_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q == TRG_FALL && prev_q && !src_in) |=> pend_q);

    // R8: an acknowledge with no competing edge or write clears an edge source.
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && trig_q[0] && !edge_hit && !sw_pend) |=> !pend_q);

endmodule

// File: rtl/irqc_pick.sv
// Winner selection over all sources. The key is the effective control byte,
// whose order equals level-then-priority order for every width setting.
// A later (higher) ID replaces an equal key.
// Assumes: elig and key come from registered state.
module irqc_pick #(
    parameter int NUM_SRC = 87,
    parameter int ID_W    = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       elig,
    input  logic [NUM_SRC-1:0][7:0]  key,
    output logic                     win_valid,
    output logic [ID_W-1:0]          win_id
);

    logic [7:0] best_key;

    // Linear scan: keep the best key, ties go to the later ID.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        best_key  = 8'd0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!win_valid || key[i] >= best_key)) begin
                win_valid = 1'b1;
                win_id    = ID_W'(i);
                best_key  = key[i];
            end
        end
    end

    // R10: the chosen source is among the eligible ones.
    p_win_eligible_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> elig[win_id]);

endmodule

// File: rtl/core_irq_ctrl.sv
// Leveled core-local interrupt controller top: register decode, per-source
// slots, winner selection and the core-side outputs.
// Assumes: all inputs are synchronous to clk, and irq_ack is a one-cycle
// pulse raised while irq_valid is high.
module core_irq_ctrl #(
    parameter int NUM_SRC  = 87,
    parameter int CTL_BITS = 4,
    parameter int VERSION  = 1,
    parameter int ADDR_W   = 16,
    localparam int ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               reg_we,
    input  logic [3:0]         reg_be,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               irq_ack,
    output logic               irq_valid,
    output logic [ID_W-1:0]    irq_id,
    output logic [7:0]         irq_level,
    output logic               irq_vec
);

    localparam int WORD_W   = ADDR_W - 2;
    localparam int SRC_BASE = 'h400;

    logic [WORD_W-1:0]        word;
    logic [WORD_W-1:0]        src_off;
    logic                     in_src;
    logic [3:0]               width;
    logic [7:0]               thr;
    logic [31:0]              cfg_word;
    logic [31:0]              thr_word;
    logic [31:0]              info_word;
    logic [NUM_SRC-1:0]       elig;
    logic [NUM_SRC-1:0][7:0]  keys;
    logic [7:0]               lvls [NUM_SRC];
    logic [31:0]              rds  [NUM_SRC];
    logic [NUM_SRC-1:0]       vecs;
    logic                     win_valid;
    logic [ID_W-1:0]          win_id;
    logic [1:0]               unused_addr;

    // Address decode into word index and source offset.
    always_comb begin
        word    = reg_addr[ADDR_W-1:2];
        src_off = word - WORD_W'(SRC_BASE);
        in_src  = (word >= WORD_W'(SRC_BASE)) && (src_off < WORD_W'(NUM_SRC));
    end

    assign unused_addr = reg_addr[1:0];

    irqc_globals #(
        .NUM_SRC (NUM_SRC),
        .CTL_BITS(CTL_BITS),
        .VERSION (VERSION)
    ) u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cfg   (reg_we && word == WORD_W'(0)),
        .wr_thr   (reg_we && word == WORD_W'(2)),
        .wr_be    (reg_be),
        .wr_data  (reg_wdata),
        .width    (width),
        .thr      (thr),
        .cfg_word (cfg_word),
        .thr_word (thr_word),
        .info_word(info_word)
    );

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            irqc_slot #(.CTL_BITS(CTL_BITS)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_in  (src_in[g]),
                .wr_sel  (reg_we && in_src && src_off == WORD_W'(g)),
                .wr_be   (reg_be),
                .wr_data (reg_wdata),
                .ack_hit (irq_ack && irq_valid && irq_id == ID_W'(g)),
                .width   (width),
                .thr     (thr),
                .eligible(elig[g]),
                .key     (keys[g]),
                .level   (lvls[g]),
                .vec     (vecs[g]),
                .rd_word (rds[g])
            );
        end
    endgenerate

    irqc_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (elig),
        .key      (keys),
        .win_valid(win_valid),
        .win_id   (win_id)
    );

    // Core-side outputs taken from the winner.
    always_comb begin
        irq_valid = win_valid;
        irq_id    = win_id;
        irq_level = win_valid ? lvls[win_id] : 8'd0;
        irq_vec   = win_valid ? vecs[win_id] : 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = 32'd0;
        if (word == WORD_W'(0))      reg_rdata = cfg_word;
        else if (word == WORD_W'(1)) reg_rdata = info_word;
        else if (word == WORD_W'(2)) reg_rdata = thr_word;
        else if (in_src)             reg_rdata = rds[ID_W'(src_off)];
    end

    // R9: a presented source always sits above the threshold register.
    p_thr_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level > thr));

endmodule

// File: tb/core_irq_ctrl_test.sv
`timescale 1ns/1ps
module core_irq_ctrl_test;

    localparam int NSRC = 87;
    localparam int IDW  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_in = '0;
    logic              reg_we = 1'b0;
    logic [3:0]        reg_be = 4'd0;
    logic [15:0]       reg_addr = 16'd0;
    logic [31:0]       reg_wdata = 32'd0;
    logic [31:0]       reg_rdata;
    logic              irq_ack = 1'b0;
    logic              irq_valid;
    logic [IDW-1:0]    irq_id;
    logic [7:0]        irq_level;
    logic              irq_vec;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    core_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .reg_we(reg_we), .reg_be(reg_be), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_id(irq_id),
        .irq_level(irq_level), .irq_vec(irq_vec)
    );

    always #4 clk = ~clk;

    // Arbitration table: four sources with IDs 5, 12, 40, 86 (index 0..3).
    typedef struct packed {
        logic [3:0] nl;
        logic [7:0] thr;
        logic [3:0] lines;
        logic [7:0] c0;
        logic [7:0] c1;
        logic [7:0] c2;
        logic [7:0] c3;
        logic       ev;
        logic [6:0] eid;
        logic [7:0] elvl;
    } row_t;

    localparam int NROW = 11;
    localparam row_t TBL [NROW] = '{
        '{4'd3,  8'h00, 4'b0000, 8'h20, 8'h20, 8'h40, 8'h20, 1'b0, 7'd0,  8'h00},
        '{4'd3,  8'h00, 4'b1111, 8'h20, 8'h20, 8'h40, 8'h20, 1'b1, 7'd40, 8'h02},
        '{4'd3,  8'h00, 4'b1011, 8'h20, 8'h20, 8'h40, 8'h20, 1'b1, 7'd86, 8'h01},
        '{4'd3,  8'h01, 4'b1011, 8'h20, 8'h20, 8'h40, 8'h20, 1'b0, 7'd0,  8'h00},
        '{4'd3,  8'h01, 4'b1111, 8'h20, 8'h20, 8'h40, 8'h20, 1'b1, 7'd40, 8'h02},
        '{4'd1,  8'h00, 4'b1111, 8'hF0, 8'hB0, 8'h90, 8'hC0, 1'b1, 7'd5,  8'h01},
        '{4'd0,  8'hFE, 4'b1111, 8'hF0, 8'hB0, 8'h90, 8'hC0, 1'b1, 7'd5,  8'hFF},
        '{4'd0,  8'hFF, 4'b1111, 8'hF0, 8'hB0, 8'h90, 8'hC0, 1'b0, 7'd0,  8'h00},
        '{4'd12, 8'hC0, 4'b1110, 8'hF0, 8'hB0, 8'h90, 8'hC0, 1'b1, 7'd86, 8'hCF},
        '{4'd8,  8'hC0, 4'b0110, 8'hF0, 8'hB0, 8'h90, 8'hC0, 1'b0, 7'd0,  8'h00},
        '{4'd3,  8'h00, 4'b1001, 8'h30, 8'h20, 8'h20, 8'h20, 1'b1, 7'd5,  8'h01}
    };

    localparam int SID [4] = '{5, 12, 40, 86};

    function automatic logic [15:0] src_addr(input int id);
        return 16'(16'h1000 + 4 * id);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_be = 4'd0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src_in = '0; irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // R1 and R2: reset values and read formats.
        bus_rd(16'h0000, d); check("R1 cfg after reset", d, 32'h0000_0001);
        bus_rd(16'h0008, d); check("R1 threshold after reset", d, 32'h0);
        bus_rd(src_addr(5), d);  check("R1 source 5 word", d, 32'h0FC0_0000);
        bus_rd(src_addr(86), d); check("R1 source 86 word", d, 32'h0FC0_0000);
        check("R1 irq_valid idle", {31'd0, irq_valid}, 32'd0);
        check("R11 irq_level idle", {24'd0, irq_level}, 32'd0);
        // R3: information word.
        bus_rd(16'h0004, d);
        check("R3 info word", d, (32'd4 << 21) | (32'd1 << 13) | 32'd87);

        // Table setup: enable the four sources, level trigger, vector on ID 40.
        for (int s = 0; s < 4; s++) begin
            bus_wr(src_addr(SID[s]), 4'b0110, ((SID[s] == 40) ? 32'h0001_0000 : 32'h0) | 32'h100);
        end
        for (int r = 0; r < NROW; r++) begin
            bus_wr(16'h0000, 4'b0001, {27'd0, TBL[r].nl, 1'b0});
            bus_wr(16'h0008, 4'b1000, {TBL[r].thr, 24'd0});
            bus_wr(src_addr(SID[0]), 4'b1000, {TBL[r].c0, 24'd0});
            bus_wr(src_addr(SID[1]), 4'b1000, {TBL[r].c1, 24'd0});
            bus_wr(src_addr(SID[2]), 4'b1000, {TBL[r].c2, 24'd0});
            bus_wr(src_addr(SID[3]), 4'b1000, {TBL[r].c3, 24'd0});
            @(negedge clk);
            for (int s = 0; s < 4; s++) src_in[SID[s]] = TBL[r].lines[s];
            repeat (2) @(negedge clk);
            #1;
            check($sformatf("R9 R10 row %0d valid", r), {31'd0, irq_valid}, {31'd0, TBL[r].ev});
            if (TBL[r].ev) begin
                check($sformatf("R10 row %0d id", r), {25'd0, irq_id}, {25'd0, TBL[r].eid});
                check($sformatf("R9 row %0d level", r), {24'd0, irq_level}, {24'd0, TBL[r].elvl});
                check($sformatf("R11 row %0d vec", r), {31'd0, irq_vec},
                      {31'd0, (TBL[r].eid == 7'd40)});
            end
        end

        do_reset();

        // R5: level trigger follows the line; writes are ignored.
        @(negedge clk); src_in[5] = 1'b1;
        @(negedge clk);
        bus_rd(src_addr(5), d); check("R5 pending follows high line", d, 32'h0FC0_0001);
        bus_wr(src_addr(5), 4'b0001, 32'h0);
        bus_rd(src_addr(5), d); check("R5 write 0 ignored", d, 32'h0FC0_0001);
        src_in[5] = 1'b0;
        @(negedge clk);
        bus_rd(src_addr(5), d); check("R5 pending follows low line", d, 32'h0FC0_0000);
        bus_wr(src_addr(5), 4'b0001, 32'h1);
        bus_rd(src_addr(5), d); check("R5 write 1 ignored", d, 32'h0FC0_0000);
        bus_wr(src_addr(5), 4'b0100, 32'h0004_0000);
        src_in[5] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_rd(src_addr(5), d); check("R5 code 10 is level", d, 32'h0FC4_0001);
        src_in[5] = 1'b0;
        bus_wr(src_addr(5), 4'b0100, 32'h0);

        // R6 and R8: rising edge and software set/clear.
        bus_wr(src_addr(12), 4'b0100, 32'h0002_0000);
        @(negedge clk); src_in[12] = 1'b1;
        @(negedge clk);
        bus_rd(src_addr(12), d); check("R6 rising edge sets", d, 32'h0FC2_0001);
        src_in[12] = 1'b0;
        @(negedge clk); @(negedge clk);
        bus_rd(src_addr(12), d); check("R6 stays after fall", d, 32'h0FC2_0001);
        bus_wr(src_addr(12), 4'b0001, 32'h0);
        bus_rd(src_addr(12), d); check("R8 software clear", d, 32'h0FC2_0000);
        bus_wr(src_addr(12), 4'b0001, 32'h1);
        bus_rd(src_addr(12), d); check("R8 software set", d, 32'h0FC2_0001);
        bus_wr(src_addr(12), 4'b0001, 32'h0);

        // R7: falling edge only.
        bus_wr(src_addr(40), 4'b0100, 32'h0006_0000);
        @(negedge clk); src_in[40] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_rd(src_addr(40), d); check("R7 rising ignored", d, 32'h0FC6_0000);
        src_in[40] = 1'b0;
        @(negedge clk);
        bus_rd(src_addr(40), d); check("R7 falling edge sets", d, 32'h0FC6_0001);

        // R8: acknowledge clears the presented edge source.
        bus_wr(src_addr(40), 4'b0010, 32'h100);
        #1;
        check("R8 presented valid", {31'd0, irq_valid}, 32'd1);
        check("R8 presented id", {25'd0, irq_id}, 32'd40);
        check("R9 width 0 gives level 255", {24'd0, irq_level}, 32'hFF);
        ack_pulse();
        check("R8 ack drops valid", {31'd0, irq_valid}, 32'd0);
        bus_rd(src_addr(40), d); check("R8 ack clears pending", d, 32'h0FC6_0100);

        // R5 and R8: acknowledge does not clear a level source.
        bus_wr(src_addr(5), 4'b0010, 32'h100);
        src_in[5] = 1'b1;
        @(negedge clk); @(negedge clk);
        #1;
        check("R5 level source presented", {25'd0, irq_id}, 32'd5);
        ack_pulse();
        check("R5 ack keeps level source", {31'd0, irq_valid}, 32'd1);

        // R11 and R10: output changes in the cycle after the line.
        bus_wr(src_addr(86), 4'b0010, 32'h100);
        @(negedge clk);
        src_in[86] = 1'b1;
        #1;
        check("R11 id unchanged before edge", {25'd0, irq_id}, 32'd5);
        @(negedge clk);
        #1;
        check("R10 tie goes to higher id", {25'd0, irq_id}, 32'd86);

        // R4 and R2: byte lanes and read-only bits.
        bus_wr(src_addr(20), 4'b0010, 32'hFFFF_FFFF);
        bus_rd(src_addr(20), d); check("R4 enable lane only", d, 32'h0FC0_0100);
        bus_wr(src_addr(20), 4'b1000, 32'hFFFF_FFFF);
        bus_rd(src_addr(20), d); check("R4 control lane only", d, 32'hFFC0_0100);
        bus_wr(src_addr(20), 4'b0100, 32'hFFFF_FFFF);
        bus_rd(src_addr(20), d); check("R2 attribute fixed bits", d, 32'hFFC7_0100);
        bus_wr(16'h0000, 4'b0001, 32'hFFFF_FFFF);
        bus_rd(16'h0000, d); check("R2 cfg read-only bits", d, 32'h0000_001F);
        bus_wr(16'h0008, 4'b0111, 32'hFFFF_FFFF);
        bus_rd(16'h0008, d); check("R4 threshold lane masked", d, 32'h0);
        bus_rd(16'h0010, d); check("R2 unmapped word", d, 32'h0);
        bus_rd(src_addr(87), d); check("R2 past last source", d, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule